// File: doc/BRIEF.md
# Burst Read Memory Target

This block answers memory read transactions on a shared, multiplexed, active-low address/data bus. In the clock where the frame strobe first falls, it samples the address and the command. If the command is a memory read and the address lies inside its window, it claims the transaction with its device-select output. It leaves the bus alone for one turnaround clock. After that it turns on its AD drivers and supplies consecutive words from a small internal word store.

The initiator paces the transfer with its ready strobe, and the block paces it with its target-ready strobe. The block can insert wait states of its own through the `wait_req` input. A word moves only when both ready strobes are low at a rising edge. The initiator marks the final data phase by raising the frame strobe. When that phase completes, the block releases device-select, target-ready and the AD drivers together.

The AD output-enable is a port of its own, so that a bus model or a checker can see the turnaround.

Top module: `burst_rd_target`

## Requirements
- R1: While `rst_n` is low, and after reset until a transaction is claimed, `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R2: A transaction is claimed when both of these hold at the rising edge where `frame_n` goes from high to low:
  - `cbe_n[3:0]` equals 4'b0110 (memory read).
  - `ad_in[31:6]` equals `BASE_ADDR[31:6]`. With the default `WORDS` of 16, the window is 64 bytes.
  When that happens, `devsel_n` goes low after that edge and stays low until the transaction ends.
- R3: `ad_oe` stays low during the turnaround clock that follows the address phase. It rises at the next edge and then stays high until the transaction ends.
- R4: The word presented for data phase k is `{16'hD00D, 16'(i)}`, where i = (`ad_in[5:2]` of the address phase + k) mod 16. The word index advances by one (4 bytes) only after a completed data phase.
- R5: When `trdy_n` is low and `irdy_n` is high at a rising edge, `trdy_n` stays low and `ad_out` keeps the same word after that edge.
- R6: At each edge where the block is not holding an untaken word (the turnaround edge, an edge with `trdy_n` high, or an edge that completes a non-final phase), the next `trdy_n` equals the `wait_req` value sampled at that edge.
- R7: A data phase is complete when `irdy_n` and `trdy_n` are both low at a rising edge. A completed phase with `frame_n` high is the last one. After it, `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R8: A transaction whose command is not a memory read is ignored: `devsel_n`, `trdy_n` and `ad_oe` stay inactive for its whole duration.
- R9: A memory read whose address lies outside the window is ignored in the same way. After such a transaction, a following in-window read is claimed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Transaction frame strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | DATA_W/8 | Command in the address phase (low four bits), byte enables afterwards |
| ad_in | input | DATA_W | Address/data lines as seen by the target |
| wait_req | input | 1 | High asks the target to hold `trdy_n` high for another clock |
| ad_out | output | DATA_W | Read data the target drives; zero while not enabled |
| ad_oe | output | 1 | Output enable for the target's AD drivers |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |

## Verification
The assertions assume an initiator that obeys the bus handshake:
- `frame_n` only falls from an idle bus.
- Once `frame_n` is high during a claimed transaction, `irdy_n` stays low until the final phase completes.
- `frame_n` stays high after the last phase until the next address phase.

The bench drives inputs at the falling edge. It raises `frame_n` only in the cycle where it drives `irdy_n` low for the final word, and never stalls after that. Idle cycles separate transactions, so every start is a clean high-to-low frame edge.

// File: rtl/burst_tgt_pkg.sv
package burst_tgt_pkg;

   localparam logic [3:0] CMD_MEM_READ      = 4'b0110;
   localparam logic [3:0] CMD_MEM_READ_MULT = 4'b1100;
   localparam logic [3:0] CMD_MEM_READ_LINE = 4'b1110;

   typedef enum logic [1:0] {
      TGT_IDLE = 2'd0,
      TGT_TURN = 2'd1,
      TGT_DATA = 2'd2
   } tgt_state_e;

   // Content of word slot idx: tag in the upper half, slot number in the lower half,
   // repeated so that a 64-bit build carries the same pattern in both lanes.
   function automatic logic [63:0] pattern_word(input logic [15:0] tag, input int unsigned idx);
      logic [15:0] slot;
      slot = 16'(idx);
      return {tag, slot, tag, slot};
   endfunction

endpackage

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode #(
   parameter int unsigned   DATA_W      = 32,
   parameter int unsigned   WIN_LSB     = 6,
   parameter int unsigned   IDX_W       = 4,
   parameter logic [63:0]   BASE_ADDR   = 64'h0,
   parameter bit            ACCEPT_MULT = 1'b0
) (
   input  logic [DATA_W-1:0]   ad,
   input  logic [DATA_W/8-1:0] cbe_n,
   output logic                hit,
   output logic [IDX_W-1:0]    start_idx
);
   import burst_tgt_pkg::*;

   localparam int unsigned CBE_W = DATA_W / 8;

   logic [3:0] cmd;
   logic       cmd_ok;
   logic       addr_ok;
   logic       unused_bits;

   assign cmd = cbe_n[3:0];

   generate
      if (ACCEPT_MULT) begin : g_cmd_all_reads
         assign cmd_ok = (cmd == CMD_MEM_READ) || (cmd == CMD_MEM_READ_MULT) ||
                         (cmd == CMD_MEM_READ_LINE);
      end else begin : g_cmd_plain_read
         assign cmd_ok = (cmd == CMD_MEM_READ);
      end

      if (CBE_W > 4) begin : g_wide_cbe
         assign unused_bits = ^{ad[1:0], cbe_n[CBE_W-1:4]};
      end else begin : g_narrow_cbe
         assign unused_bits = ^ad[1:0];
      end
   endgenerate

   assign addr_ok   = (ad[DATA_W-1:WIN_LSB] == BASE_ADDR[DATA_W-1:WIN_LSB]);
   assign hit       = cmd_ok && addr_ok;
   assign start_idx = ad[WIN_LSB-1:2];

endmodule

// File: rtl/tgt_word_rom.sv
module tgt_word_rom #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 16,
   parameter int unsigned IDX_W  = 4,
   parameter logic [15:0] TAG    = 16'hD00D
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   import burst_tgt_pkg::*;

   logic [DATA_W-1:0] slots [WORDS];

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_slot
         localparam logic [63:0] FULL = pattern_word(TAG, g);
         assign slots[g] = FULL[DATA_W-1:0];
      end
   endgenerate

   assign word = slots[idx];

endmodule

// File: rtl/tgt_burst_fsm.sv
module tgt_burst_fsm #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             hit,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             wait_req,
   output logic             devsel_n,
   output logic             trdy_n,
   output logic             ad_oe,
   output logic [IDX_W-1:0] idx
);
   import burst_tgt_pkg::*;

   tgt_state_e state_q;
   tgt_state_e state_d;
   logic       devsel_d;
   logic       trdy_d;
   logic       oe_d;
   logic [IDX_W-1:0] idx_d;
   logic       xfer;
   logic       last_xfer;

   assign xfer      = (state_q == TGT_DATA) && !irdy_n && !trdy_n;
   assign last_xfer = xfer && frame_n;

   always_comb begin
      state_d  = state_q;
      devsel_d = devsel_n;
      trdy_d   = trdy_n;
      oe_d     = ad_oe;
      idx_d    = idx;
      unique case (state_q)
         TGT_IDLE: begin
            if (start && hit) begin
               state_d  = TGT_TURN;
               devsel_d = 1'b0;
               idx_d    = start_idx;
            end
         end
         TGT_TURN: begin
            state_d = TGT_DATA;
            oe_d    = 1'b1;
            trdy_d  = wait_req;
         end
         TGT_DATA: begin
            if (last_xfer) begin
               state_d  = TGT_IDLE;
               devsel_d = 1'b1;
               trdy_d   = 1'b1;
               oe_d     = 1'b0;
            end else if (xfer) begin
               idx_d  = idx + 1'b1;
               trdy_d = wait_req;
            end else if (trdy_n) begin
               trdy_d = wait_req;
            end
         end
         default: begin
            state_d  = TGT_IDLE;
            devsel_d = 1'b1;
            trdy_d   = 1'b1;
            oe_d     = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= TGT_IDLE;
         devsel_n <= 1'b1;
         trdy_n   <= 1'b1;
         ad_oe    <= 1'b0;
         idx      <= '0;
      end else begin
         state_q  <= state_d;
         devsel_n <= devsel_d;
         trdy_n   <= trdy_d;
         ad_oe    <= oe_d;
         idx      <= idx_d;
      end
   end

endmodule

// File: rtl/burst_rd_target.sv
module burst_rd_target #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned WORDS       = 16,
   parameter logic [63:0] BASE_ADDR   = 64'h0000_0000_4000_0000,
   parameter logic [15:0] DATA_TAG    = 16'hD00D,
   parameter bit          ACCEPT_MULT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_n,
   input  logic                irdy_n,
   input  logic [DATA_W/8-1:0] cbe_n,
   input  logic [DATA_W-1:0]   ad_in,
   input  logic                wait_req,
   output logic [DATA_W-1:0]   ad_out,
   output logic                ad_oe,
   output logic                devsel_n,
   output logic                trdy_n
);

   localparam int unsigned IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int unsigned WIN_LSB = IDX_W + 2;

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
         $error("burst_rd_target: DATA_W must be 32 or 64");
      end
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("burst_rd_target: WORDS must be a power of two of at least 2");
      end
      if (WIN_LSB >= DATA_W) begin : g_bad_window
         $error("burst_rd_target: window wider than the address");
      end
      if ((BASE_ADDR & ((64'd1 << WIN_LSB) - 64'd1)) != 64'd0) begin : g_bad_base
         $error("burst_rd_target: BASE_ADDR not aligned to the window size");
      end
   endgenerate

   logic             frame_q;
   logic             frame_fall;
   logic             hit;
   logic [IDX_W-1:0] start_idx;
   logic [IDX_W-1:0] idx;
   logic [DATA_W-1:0] word;

   always_ff @(posedge clk) begin
      if (!rst_n) frame_q <= 1'b1;
      else        frame_q <= frame_n;
   end

   assign frame_fall = frame_q && !frame_n;

   tgt_addr_decode #(
      .DATA_W      (DATA_W),
      .WIN_LSB     (WIN_LSB),
      .IDX_W       (IDX_W),
      .BASE_ADDR   (BASE_ADDR),
      .ACCEPT_MULT (ACCEPT_MULT)
   ) u_decode (
      .ad        (ad_in),
      .cbe_n     (cbe_n),
      .hit       (hit),
      .start_idx (start_idx)
   );

   tgt_burst_fsm #(
      .IDX_W (IDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (frame_fall),
      .hit       (hit),
      .start_idx (start_idx),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .wait_req  (wait_req),
      .devsel_n  (devsel_n),
      .trdy_n    (trdy_n),
      .ad_oe     (ad_oe),
      .idx       (idx)
   );

   tgt_word_rom #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS),
      .IDX_W  (IDX_W),
      .TAG    (DATA_TAG)
   ) u_rom (
      .idx  (idx),
      .word (word)
   );

   assign ad_out = ad_oe ? word : '0;

endmodule

// File: rtl/burst_rd_target_chk.sv
module burst_rd_target_chk #(
   parameter int unsigned DATA_W      = 32,
   parameter bit          ACCEPT_MULT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              irdy_n,
   input logic [3:0]        cmd_n,
   input logic              wait_req,
   input logic [DATA_W-1:0] ad_out,
   input logic              ad_oe,
   input logic              devsel_n,
   input logic              trdy_n
);
   import burst_tgt_pkg::*;

   logic last_phase;
   assign last_phase = !devsel_n && ad_oe && !irdy_n && !trdy_n && frame_n;

   // R2
   devsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && !last_phase) |=> !devsel_n);

   // R3
   turnaround_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> !ad_oe);

   // R3
   drivers_follow_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |=> ad_oe);

   // R3
   oe_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> !devsel_n);

   // R5
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe && !trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

   // R6
   wait_keeps_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && trdy_n && wait_req) |=> trdy_n);

   // R6
   trdy_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> ad_oe);

   // R7
   release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_phase |=> (devsel_n && trdy_n && !ad_oe));

   // R8
   foreign_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ACCEPT_MULT && devsel_n && $fell(frame_n) && cmd_n != CMD_MEM_READ) |=> devsel_n);

endmodule

bind burst_rd_target burst_rd_target_chk #(
   .DATA_W      (DATA_W),
   .ACCEPT_MULT (ACCEPT_MULT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .cmd_n    (cbe_n[3:0]),
   .wait_req (wait_req),
   .ad_out   (ad_out),
   .ad_oe    (ad_oe),
   .devsel_n (devsel_n),
   .trdy_n   (trdy_n)
);

// File: tb/burst_rd_target_test.sv
`timescale 1ns/1ps
module burst_rd_target_test;

   localparam logic [31:0] BASE = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic [3:0]  cbe_n = 4'h0;
   logic [31:0] ad_in = 32'h0;
   logic        wait_req = 1'b0;
   logic [31:0] ad_out;
   logic        ad_oe;
   logic        devsel_n;
   logic        trdy_n;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   burst_rd_target uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .irdy_n   (irdy_n),
      .cbe_n    (cbe_n),
      .ad_in    (ad_in),
      .wait_req (wait_req),
      .ad_out   (ad_out),
      .ad_oe    (ad_oe),
      .devsel_n (devsel_n),
      .trdy_n   (trdy_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [31:0] addr, input int k);
      logic [3:0] slot;
      slot = 4'(addr[5:2] + k);
      return {16'hD00D, 12'h000, slot};
   endfunction

   task automatic check_idle(input string req, input string what);
      check(devsel_n === 1'b1, req, {what, " devsel_n"}, {31'd0, devsel_n}, 32'd1);
      check(trdy_n === 1'b1, req, {what, " trdy_n"}, {31'd0, trdy_n}, 32'd1);
      check(ad_oe === 1'b0, req, {what, " ad_oe"}, {31'd0, ad_oe}, 32'd0);
   endtask

   // One claimed read burst of n words; stall_mask / wait_mask give, per cycle after
   // the address phase, whether the initiator withholds irdy_n and whether wait_req is set.
   task automatic run_burst(input logic [31:0] addr, input int n,
                            input logic [31:0] stall_mask, input logic [31:0] wait_mask,
                            input string tag);
      int   k = 0;
      bit   frame_hi = 1'b0;
      logic exp_trdy = 1'b1;
      bit   held = 1'b0;
      @(negedge clk);
      frame_n = 1'b0; ad_in = addr; cbe_n = 4'b0110; irdy_n = 1'b1; wait_req = 1'b0;
      for (int i = 0; i < 64 && k < n; i++) begin
         bit stall;
         bit done;
         @(negedge clk);
         check(devsel_n === 1'b0, "R2", {tag, " devsel_n during burst"}, {31'd0, devsel_n}, 32'd0);
         if (i == 0)
            check(ad_oe === 1'b0, "R3", {tag, " ad_oe in turnaround"}, {31'd0, ad_oe}, 32'd0);
         else
            check(ad_oe === 1'b1, "R3", {tag, " ad_oe after turnaround"}, {31'd0, ad_oe}, 32'd1);
         check(trdy_n === exp_trdy, held ? "R5" : "R6", {tag, " trdy_n"}, {31'd0, trdy_n}, {31'd0, exp_trdy});
         if (trdy_n === 1'b0)
            check(ad_out === exp_word(addr, k), held ? "R5" : "R4", {tag, " data word"},
                  ad_out, exp_word(addr, k));
         stall = stall_mask[i] && !frame_hi;
         irdy_n = stall;
         if (k == n - 1 && !stall) frame_hi = 1'b1;
         frame_n = frame_hi;
         ad_in = 32'h0; cbe_n = 4'h0;
         wait_req = wait_mask[i];
         done = (trdy_n === 1'b0) && !stall;
         held = (trdy_n === 1'b0) && stall;
         if (done) begin
            k++;
            exp_trdy = wait_mask[i];
         end else begin
            exp_trdy = (trdy_n === 1'b0) ? 1'b0 : wait_mask[i];
         end
      end
      check(k == n, "R4", {tag, " words transferred"}, 32'(k), 32'(n));
      @(negedge clk);
      check_idle("R7", {tag, " release after last phase"});
      irdy_n = 1'b1; frame_n = 1'b1; wait_req = 1'b0;
   endtask

   task automatic run_ignored(input logic [31:0] addr, input logic [3:0] cmd,
                              input string req, input string tag);
      @(negedge clk);
      frame_n = 1'b0; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_idle(req, tag);
         ad_in = 32'h0; cbe_n = 4'h0; irdy_n = 1'b0;
         frame_n = (i >= 2);
      end
      @(negedge clk);
      check_idle(req, {tag, " after end"});
      irdy_n = 1'b1; frame_n = 1'b1;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_idle("R1", "during reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1", "after reset");
   endtask

   task automatic test_plain();
      run_burst(BASE + 32'h10, 4, 32'h0, 32'h0, "plain burst");
   endtask

   task automatic test_wrap();
      run_burst(BASE + 32'h38, 4, 32'h0, 32'h0, "wrapping burst");
   endtask

   task automatic test_stall();
      run_burst(BASE + 32'h04, 5, 32'b0001_0100, 32'h0, "initiator stall");
   endtask

   task automatic test_wait();
      run_burst(BASE + 32'h20, 4, 32'h0, 32'b0011_0011, "target wait");
   endtask

   task automatic test_mixed();
      run_burst(BASE + 32'h3C, 3, 32'b0100_1000, 32'b0000_0110, "mixed pacing");
   endtask

   task automatic test_single();
      run_burst(BASE + 32'h08, 1, 32'h0, 32'h0, "single word");
   endtask

   task automatic test_bad_cmd();
      run_ignored(BASE + 32'h10, 4'b0111, "R8", "write command ignored");
      run_ignored(BASE + 32'h10, 4'b1100, "R8", "read-multiple ignored");
   endtask

   task automatic test_out_of_window();
      run_ignored(BASE + 32'h40, 4'b0110, "R9", "above window ignored");
      run_ignored(BASE - 32'h04, 4'b0110, "R9", "below window ignored");
      run_burst(BASE + 32'h00, 2, 32'h0, 32'h0, "R9 claim after ignored");
   endtask

   initial begin
      test_reset();
      test_plain();
      test_wrap();
      test_stall();
      test_wait();
      test_mixed();
      test_single();
      test_bad_cmd();
      test_out_of_window();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule